// File: doc/BRIEF.md
# Scrambled Word Memory Access Pipeline

This block sits between a bus-side request port and a single-port word memory with one cycle of read latency. Each request carries a read/write flag, a word address, a write word and a per-byte write mask. Reads and full-word writes go to the memory in the cycle they are accepted, so the port sustains one access per cycle. Read data comes back one cycle later, in request order.

The memory holds scrambled words. A word is stored as the write data XOR a keystream word taken from a side input, and it is descrambled with the keystream present when a read is accepted. Scrambling works on whole words, so a write that enables only some bytes becomes an internal read-modify-write. The block reads the stored word, descrambles it, merges in the enabled bytes, scrambles the result and writes it back. The request port stalls for the two extra cycles this takes. Word addresses pass through a fixed bijective bit permutation and XOR before they reach the memory.

Top module: `mem_rmw_pipe`

## Requirements
- R1: During and right after reset, gnt_o is 1 and rvalid_o is 0.
- R2: Reads and full-word writes (be_i all ones) never drop gnt_o. N back-to-back reads with no idle cycles span N+1 cycles, from the cycle of the first request to the cycle of the last response.
- R3: A read accepted in cycle t (req_i and gnt_o both high) raises rvalid_o with its data in cycle t+1. Responses come only for reads and in request order.
- R4: A write whose mask is not all ones holds gnt_o low for exactly the two cycles after it is accepted.
- R5: Mask bit i selects byte i, bits 8i+7 down to 8i, of the word. A masked write replaces the enabled bytes and keeps the others. This holds for all 16 masks of a 4-byte word.
- R6: A write with an all-zero mask leaves the stored word unchanged.
- R7: A read issued right after a write to the same address, whether the write is full or masked, returns the new data. A read followed at once by a write to the same address returns the old data.
- R8: The address mapping is a bijection. Writing every address with its own index and then reading all of them back returns each index.
- R9: The memory holds write data XOR key_i as sampled when the write is accepted. A read returns the stored word XOR key_i as sampled when the read is accepted.
- R10: A request presented while gnt_o is low has no effect. It writes nothing and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| key_i | input | DW | Keystream word used for scrambling |
| req_i | input | 1 | Request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address |
| be_i | input | DW/8 | Per-byte write enable |
| wdata_i | input | DW | Write data |
| gnt_o | output | 1 | Request accepted this cycle when high together with req_i |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | DW | Read data |

## Verification
An ascending write of every address followed by a burst of 64 reads gives two results. It shows that no two addresses collide, and it times the full-word throughput. A sweep over all 16 masks on a known background word separates correct byte steering from swapped or dropped lanes, and the all-zero mask shows that a masked write has no side effects. Same-address pairs (write then read, masked write then read, read then write) expose stale data or ordering slips. A stream of masked writes pins the stall to exactly two cycles. Changing the keystream between a write and a read shows which sample of the key each operation uses. Garbage driven during a stall shows that stalled requests are dropped.

// File: rtl/mrp_pkg.sv
package mrp_pkg;

    // Sequencer state of the access pipeline
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // accepting requests
        ST_MERGE = 2'd1,   // old word arriving, merge enabled bytes
        ST_WRITE = 2'd2    // write merged word back
    } seq_e;

endpackage

// File: rtl/mrp_addr_map.sv
// Bijective logical-to-physical word address map: rotate the bits, then XOR a constant.
module mrp_addr_map #(
    parameter int unsigned AW    = 6,
    parameter int unsigned ROT   = 1,
    parameter int unsigned TWEAK = 'h2A
) (
    input  logic [AW-1:0] log_i,
    output logic [AW-1:0] phy_o
);
    localparam logic [AW-1:0] TW = AW'(TWEAK);

    for (genvar i = 0; i < AW; i++) begin : g_bit
        assign phy_o[i] = log_i[(i + ROT) % AW] ^ TW[i];
    end
endmodule

// File: rtl/mrp_byte_merge.sv
// Byte-lane merge: enabled lanes from the new word, the rest from the old word.
module mrp_byte_merge #(
    parameter int unsigned DW = 32,
    localparam int unsigned NB = DW / 8
) (
    input  logic [DW-1:0] old_i,
    input  logic [DW-1:0] new_i,
    input  logic [NB-1:0] en_i,
    output logic [DW-1:0] out_o
);
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign out_o[8*b +: 8] = en_i[b] ? new_i[8*b +: 8] : old_i[8*b +: 8];
    end
endmodule

// File: rtl/mrp_sp_ram.sv
// Single-port word memory, synchronous read with one cycle of latency.
module mrp_sp_ram #(
    parameter int unsigned AW = 6,
    parameter int unsigned DW = 32,
    localparam int unsigned DEPTH = 1 << AW
) (
    input  logic          clk_i,
    input  logic          en_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wd_i,
    output logic [DW-1:0] rd_o
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk_i) begin
        if (en_i) begin
            if (we_i) begin
                mem_q[addr_i] <= wd_i;
            end else begin
                rd_q <= mem_q[addr_i];
            end
        end
    end

    assign rd_o = rd_q;
endmodule

// File: rtl/mem_rmw_pipe.sv
module mem_rmw_pipe #(
    parameter int unsigned AW    = 6,
    parameter int unsigned DW    = 32,
    parameter int unsigned ROT   = 1,
    parameter int unsigned TWEAK = 'h2A,
    localparam int unsigned NB   = DW / 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [DW-1:0] key_i,
    input  logic          req_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [NB-1:0] be_i,
    input  logic [DW-1:0] wdata_i,
    output logic          gnt_o,
    output logic          rvalid_o,
    output logic [DW-1:0] rdata_o
);
    import mrp_pkg::*;

    localparam logic [NB-1:0] FULL = '1;

    typedef struct packed {
        seq_e          st;
        logic          rvalid;
        logic [AW-1:0] addr;   // physical address of pending masked write
        logic [NB-1:0] be;
        logic [DW-1:0] key;    // key of last read or pending masked write
        logic [DW-1:0] wdata;
        logic [DW-1:0] wb;     // scrambled merged word to write back
    } pipe_t;

    localparam pipe_t PIPE_RST = '{st: ST_IDLE, rvalid: 1'b0, addr: '0, be: '0,
                                   key: '0, wdata: '0, wb: '0};

    pipe_t s_d, s_q;

    logic [AW-1:0] phys_addr;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wd, mem_rd;
    logic [DW-1:0] merged;

    mrp_addr_map #(.AW(AW), .ROT(ROT), .TWEAK(TWEAK)) u_map (
        .log_i (addr_i),
        .phy_o (phys_addr)
    );

    mrp_byte_merge #(.DW(DW)) u_merge (
        .old_i (mem_rd ^ s_q.key),
        .new_i (s_q.wdata),
        .en_i  (s_q.be),
        .out_o (merged)
    );

    mrp_sp_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk_i  (clk_i),
        .en_i   (mem_en),
        .we_i   (mem_we),
        .addr_i (mem_addr),
        .wd_i   (mem_wd),
        .rd_o   (mem_rd)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        mem_en     = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = phys_addr;
        mem_wd     = wdata_i ^ key_i;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    mem_en = 1'b1;
                    if (!we_i) begin
                        s_d.rvalid = 1'b1;
                        s_d.key    = key_i;
                    end else if (be_i == FULL) begin
                        mem_we = 1'b1;
                    end else begin
                        // masked write: this cycle fetches the old word
                        s_d.st    = ST_MERGE;
                        s_d.addr  = phys_addr;
                        s_d.be    = be_i;
                        s_d.wdata = wdata_i;
                        s_d.key   = key_i;
                    end
                end
            end
            ST_MERGE: begin
                s_d.wb = merged ^ s_q.key;
                s_d.st = ST_WRITE;
            end
            ST_WRITE: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                mem_addr = s_q.addr;
                mem_wd   = s_q.wb;
                s_d.st   = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= PIPE_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign gnt_o    = (s_q.st == ST_IDLE);
    assign rvalid_o = s_q.rvalid;
    assign rdata_o  = mem_rd ^ s_q.key;
endmodule

// File: rtl/mrp_checker.sv
module mrp_checker #(
    parameter int unsigned NB = 4
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          req_i,
    input logic          we_i,
    input logic [NB-1:0] be_i,
    input logic          gnt_o,
    input logic          rvalid_o
);
    logic acc, rd_acc, full_acc, part_acc;
    assign acc      = req_i && gnt_o;
    assign rd_acc   = acc && !we_i;
    assign full_acc = acc && we_i && (be_i == '1);
    assign part_acc = acc && we_i && (be_i != '1);

    // R4
    partial_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        part_acc |=> (!gnt_o ##1 !gnt_o ##1 gnt_o));

    // R2
    full_nostall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_acc || rd_acc) |=> gnt_o);

    // R3
    rsp_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_acc |=> rvalid_o);

    // R3
    rsp_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rvalid_o |-> $past(rd_acc));

    // R10
    stall_no_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !gnt_o) |=> !rvalid_o);
endmodule

bind mem_rmw_pipe mrp_checker #(.NB(NB)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .be_i     (be_i),
    .gnt_o    (gnt_o),
    .rvalid_o (rvalid_o)
);

// File: tb/tb_mem_rmw_pipe.sv
module tb_mem_rmw_pipe;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int NB = DW / 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] key = 32'h0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [NB-1:0] be = '0;
    logic [DW-1:0] wdata = '0;
    logic          gnt, rvalid;
    logic [DW-1:0] rdata;

    mem_rmw_pipe #(.AW(AW), .DW(DW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .key_i(key), .req_i(req), .we_i(we),
        .addr_i(addr), .be_i(be), .wdata_i(wdata), .gnt_o(gnt),
        .rvalid_o(rvalid), .rdata_o(rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    int stalls = 0;
    int cyc = 0;
    int last_rv_cyc = 0;
    logic [DW-1:0] smem [DEPTH];   // model of scrambled storage
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            last_rv_cyc = cyc;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3/R10 unexpected response", rdata, '0);
            end else begin
                automatic logic [DW-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(rdata === e, t, rdata, e);
            end
        end
    end

    // driver: called at a negedge, returns at the negedge after acceptance
    task automatic issue(input bit w, input int a, input logic [NB-1:0] m,
                         input logic [DW-1:0] d, input string tag);
        req = 1'b1; we = w; addr = AW'(a); be = m; wdata = d;
        while (!gnt) begin
            stalls++;
            @(negedge clk);
        end
        if (!w) begin
            exp_q.push_back(smem[a] ^ key);
            tag_q.push_back(tag);
        end else begin
            automatic logic [DW-1:0] old = smem[a] ^ key;
            for (int b = 0; b < NB; b++)
                if (m[b]) old[8*b +: 8] = d[8*b +: 8];
            smem[a] = old ^ key;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        req = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int c0;
        key = 32'h5EC0_3A71;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(gnt === 1'b1, "R1 gnt in reset", DW'(gnt), 1);
        chk(rvalid === 1'b0, "R1 rvalid in reset", DW'(rvalid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(gnt === 1'b1 && rvalid === 1'b0, "R1 after reset", {gnt, rvalid}, 2'b10);

        // R8: every address gets its own index, then one read burst
        stalls = 0;
        for (int a = 0; a < DEPTH; a++) issue(1'b1, a, '1, DW'(a), "R8 write");
        c0 = cyc;
        for (int a = 0; a < DEPTH; a++) issue(1'b0, a, '1, 0, "R8 bijection readback");
        idle(3);
        // R2: no stalls and N+1 cycles for N reads
        chk(stalls == 0, "R2 full-word stalls", stalls, 0);
        chk(last_rv_cyc - c0 + 1 == DEPTH + 1, "R2 read burst span",
            last_rv_cyc - c0 + 1, DEPTH + 1);

        // R5/R6: every mask on a known background word
        for (int m = 0; m < 16; m++) begin
            issue(1'b1, 16 + m, '1, 32'hA5C3_96F0, "R5 background");
            issue(1'b1, 16 + m, NB'(m), 32'h1122_3344 + m, "R5 masked write");
            issue(1'b0, 16 + m, '1, 0, (m == 0) ? "R6 zero mask readback" : "R5 merge readback");
        end
        idle(3);

        // R7: same-address back-to-back pairs
        issue(1'b1, 40, '1, 32'hDEAD_BEEF, "R7 w");
        issue(1'b0, 40, '1, 0, "R7 read after full write");
        issue(1'b1, 40, 4'b0110, 32'h0BAD_F00D, "R7 pw");
        issue(1'b0, 40, '1, 0, "R7 read after masked write");
        issue(1'b0, 41, '1, 0, "R7 read before write");
        issue(1'b1, 41, '1, 32'h7777_0001, "R7 w2");
        issue(1'b0, 41, '1, 0, "R7 read after write after read");
        idle(3);

        // R4: three masked writes back to back, then a read
        stalls = 0;
        issue(1'b1, 42, 4'b0001, 32'h0000_00AA, "R4 p1");
        issue(1'b1, 42, 4'b0100, 32'h00BB_0000, "R4 p2");
        issue(1'b1, 42, 4'b1000, 32'hCC00_0000, "R4 p3");
        issue(1'b0, 42, '1, 0, "R4 readback");
        idle(3);
        chk(stalls == 6, "R4 stall cycles", stalls, 6);

        // R10: garbage during a stall is dropped
        issue(1'b1, 43, 4'b0011, 32'h0000_1234, "R10 pw");
        req = 1'b1; we = 1'b1; addr = 6'd44; be = '1; wdata = 32'hFFFF_FFFF;
        chk(gnt === 1'b0, "R10 stalled", DW'(gnt), 0);
        @(negedge clk);
        @(negedge clk);
        idle(1);
        issue(1'b0, 44, '1, 0, "R10 stalled write ignored");
        issue(1'b0, 43, '1, 0, "R10 masked write intact");
        idle(3);

        // R9: key sampled at write, separately at read
        issue(1'b1, 50, '1, 32'h0F0F_1234, "R9 w");
        key = 32'h1357_9BDF;
        issue(1'b0, 50, '1, 0, "R9 read under new key");
        issue(1'b1, 51, 4'b1010, 32'hAB00_CD00, "R9 pw");
        key = 32'h5EC0_3A71;
        issue(1'b0, 51, '1, 0, "R9 masked under other key");
        idle(4);

        chk(exp_q.size() == 0, "R3 all responses seen", exp_q.size(), 0);
        finish_run();
    end
endmodule